// File: doc/BRIEF.md
# SCL Timebase Generator

This block produces the serial clock timing for a two-wire bus master. A prescaler turns the system clock into a slower reference tick, with a programmable number of system clocks per tick. The intended setting gives a tick of roughly 10 MHz. The phase sequencer then holds SCL low for one programmable number of reference ticks and leaves it released for another. These two counts are independent 8-bit fields of one divider word, so the duty cycle is set directly and not through a single divide ratio.

A master sequencer raises `xfer_run` to request clock pulses. The block reports three events with one-cycle strobes:
- the falling edge of SCL;
- the middle of each low phase, where SDA may be changed;
- the rising edge of SCL, where SDA is sampled.

After the block releases SCL, it does not start counting the high phase until SCL is actually sensed high. This lets a slave stretch the clock. Dropping the interface enable clears all timing state.

Top module: `scl_timebase`

## Requirements
- R1: While `iface_en` is 1 and no SCL phase starts, `ref_tick` pulses once every P system clocks, where P is `ref_div` and a `ref_div` of 0 counts as 1. After `iface_en` rises, the first pulse falls in the P-th enabled cycle.
- R2: While `iface_en` is 0, every output is 0 and both counters are held cleared. When `iface_en` is set again, the prescaler restarts from zero and the sequencer starts in the idle state, with SCL released.
- R3: In the idle state with `iface_en` and `xfer_run` both 1, `scl_fall_stb` is 1 in that cycle and `scl_pull_low` is 1 from the next cycle on.
- R4: `scl_pull_low` stays 1 for exactly L·P system clocks, where L is `scl_div[7:0]` (0 counts as 1). The prescaler restarts when the low phase begins.
- R5: `sda_shift_stb` pulses once per low phase, on low-phase tick number floor((L-1)/2)+1. That tick is P·(floor((L-1)/2)+1) cycles after `scl_fall_stb`.
- R6: After release, the high count waits until `scl_in` is 1. `scl_rise_stb` pulses in the first released cycle with `scl_in` high, and SCL is not pulled low while it waits.
- R7: The high phase lasts H ticks after the cycle of `scl_rise_stb`, where H is `scl_div[15:8]` (0 counts as 1). At its last tick, the block starts a new low phase with `scl_fall_stb` if `xfer_run` is 1. Otherwise it returns to idle and keeps SCL released.
- R8: A count field of 255 gives 255 reference periods, the slowest bus rate. One full SCL period lasts (L+H)·P+1 cycles, plus any stretch cycles.
- R9: `scl_fall_stb` and `scl_rise_stb` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iface_en | input | 1 | Interface enable; 0 clears all timing state |
| ref_div | input | 7 | System clocks per reference tick |
| scl_div | input | 16 | [7:0] low ticks, [15:8] high ticks |
| xfer_run | input | 1 | Request from the master sequencer to keep clocking |
| scl_in | input | 1 | Sensed level of the SCL line |
| ref_tick | output | 1 | Reference tick, one cycle wide |
| scl_pull_low | output | 1 | Drive SCL low when 1 |
| scl_fall_stb | output | 1 | SCL falling edge is being started |
| sda_shift_stb | output | 1 | Mid-low point, where SDA may change |
| scl_rise_stb | output | 1 | SCL seen high; SDA sample point |

## Verification
With a low count of 1, the mid-low strobe and the tick that ends the low phase fall in the same cycle. This is provoked by the table rows whose low field is 0 or 1. The check is that the strobe appears exactly P cycles after the fall strobe, and that the low phase still lasts exactly P cycles. A stretch run holds `scl_in` low for five extra cycles after release. It is judged by the rise strobe and the next fall strobe both moving by exactly five cycles.

// File: rtl/scl_timebase_pkg.sv
package scl_timebase_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_WAIT = 2'd2,
      PH_HIGH = 2'd3
   } scl_phase_e;

endpackage

// File: rtl/scl_ref_prescaler.sv
module scl_ref_prescaler #(
   parameter int PRE_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             restart,
   input  logic [PRE_W-1:0] div,
   output logic             tick
);

   generate
      if (PRE_W < 1 || PRE_W > 16) begin : g_bad_width
         $error("scl_ref_prescaler: PRE_W out of range");
      end
   endgenerate

   logic [PRE_W-1:0] cnt_q;
   logic [PRE_W-1:0] div_m1;

   // A divide value of zero behaves as one.
   assign div_m1 = (div == '0) ? '0 : div - 1'b1;
   assign tick   = en && (cnt_q >= div_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!en || restart || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && en && div_m1 != '0) |=> (!tick || !$stable(div))) else $error("tick gap"); // R1

   AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0)) else $error("prescaler not cleared"); // R2

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
   import scl_timebase_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter bit STRETCH_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             run,
   input  logic             tick,
   input  logic             scl_sense,
   input  logic [CNT_W-1:0] lo_cnt,
   input  logic [CNT_W-1:0] hi_cnt,
   output logic             drive_low,
   output logic             fall_stb,
   output logic             mid_stb,
   output logic             rise_stb,
   output logic             restart
);

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("scl_phase_seq: CNT_W out of range");
      end
   endgenerate

   scl_phase_e       st_q;
   logic [CNT_W-1:0] pcnt_q;
   logic [CNT_W-1:0] lo_m1;
   logic [CNT_W-1:0] hi_m1;
   logic [CNT_W-1:0] mid_idx;
   logic             lo_last;
   logic             hi_last;
   logic             sense_ok;

   // Choose whether a slave may hold the clock low.
   generate
      if (STRETCH_EN) begin : g_stretch
         assign sense_ok = scl_sense;
      end else begin : g_no_stretch
         assign sense_ok = 1'b1;
      end
   endgenerate

   assign lo_m1   = (lo_cnt == '0) ? '0 : lo_cnt - 1'b1;
   assign hi_m1   = (hi_cnt == '0) ? '0 : hi_cnt - 1'b1;
   assign mid_idx = lo_m1 >> 1;
   assign lo_last = (pcnt_q >= lo_m1);
   assign hi_last = (pcnt_q >= hi_m1);

   always_comb begin
      fall_stb  = en && run &&
                  ((st_q == PH_IDLE) || (st_q == PH_HIGH && tick && hi_last));
      rise_stb  = en && (st_q == PH_WAIT) && sense_ok;
      mid_stb   = en && (st_q == PH_LOW) && tick && (pcnt_q == mid_idx);
      drive_low = en && (st_q == PH_LOW);
      restart   = fall_stb || rise_stb;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PH_IDLE;
         pcnt_q <= '0;
      end else if (!en) begin
         st_q   <= PH_IDLE;
         pcnt_q <= '0;
      end else begin
         unique case (st_q)
            PH_IDLE: begin
               if (fall_stb) begin
                  st_q   <= PH_LOW;
                  pcnt_q <= '0;
               end
            end
            PH_LOW: begin
               if (tick) begin
                  if (lo_last) begin
                     st_q   <= PH_WAIT;
                     pcnt_q <= '0;
                  end else begin
                     pcnt_q <= pcnt_q + 1'b1;
                  end
               end
            end
            PH_WAIT: begin
               if (rise_stb) begin
                  st_q   <= PH_HIGH;
                  pcnt_q <= '0;
               end
            end
            PH_HIGH: begin
               if (tick) begin
                  if (hi_last) begin
                     st_q   <= fall_stb ? PH_LOW : PH_IDLE;
                     pcnt_q <= '0;
                  end else begin
                     pcnt_q <= pcnt_q + 1'b1;
                  end
               end
            end
            default: begin
               st_q   <= PH_IDLE;
               pcnt_q <= '0;
            end
         endcase
      end
   end

   AST_LOW_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_stb && en) |=> (drive_low || !en)) else $error("no low after fall"); // R3

   AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && $fell(drive_low)) |-> $past(tick)) else $error("release off tick"); // R4

   AST_MID_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      mid_stb |-> drive_low) else $error("mid strobe outside low"); // R5

   AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && st_q == PH_WAIT && !sense_ok) |=> !drive_low) else $error("pulled low while stretched"); // R6

   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (st_q == PH_IDLE && pcnt_q == '0)) else $error("state kept while disabled"); // R2

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fall_stb, rise_stb})) else $error("fall and rise together"); // R9

endmodule

// File: rtl/scl_timebase.sv
module scl_timebase #(
   parameter int PRE_W      = 7,
   parameter int CNT_W      = 8,
   parameter bit STRETCH_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               iface_en,
   input  logic [PRE_W-1:0]   ref_div,
   input  logic [2*CNT_W-1:0] scl_div,
   input  logic               xfer_run,
   input  logic               scl_in,
   output logic               ref_tick,
   output logic               scl_pull_low,
   output logic               scl_fall_stb,
   output logic               sda_shift_stb,
   output logic               scl_rise_stb
);

   localparam int DIV_W = 2 * CNT_W;

   generate
      if (DIV_W != 2 * CNT_W) begin : g_bad_div
         $error("scl_timebase: divider width mismatch");
      end
   endgenerate

   logic             restart;
   logic [CNT_W-1:0] lo_cnt;
   logic [CNT_W-1:0] hi_cnt;

   assign lo_cnt = scl_div[CNT_W-1:0];
   assign hi_cnt = scl_div[DIV_W-1:CNT_W];

   scl_ref_prescaler #(
      .PRE_W (PRE_W)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (iface_en),
      .restart (restart),
      .div     (ref_div),
      .tick    (ref_tick)
   );

   scl_phase_seq #(
      .CNT_W      (CNT_W),
      .STRETCH_EN (STRETCH_EN)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (iface_en),
      .run       (xfer_run),
      .tick      (ref_tick),
      .scl_sense (scl_in),
      .lo_cnt    (lo_cnt),
      .hi_cnt    (hi_cnt),
      .drive_low (scl_pull_low),
      .fall_stb  (scl_fall_stb),
      .mid_stb   (sda_shift_stb),
      .rise_stb  (scl_rise_stb),
      .restart   (restart)
   );

endmodule

// File: tb/scl_timebase_tb.sv
`timescale 1ns/1ps
module scl_timebase_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [6:0]  pre = '0;
   logic [15:0] div = '0;
   logic        run = 1'b0;
   logic        stretch = 1'b0;
   logic        scl_in;
   logic        tick, pull_low, fall_stb, mid_stb, rise_stb;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   // Open-drain bus model; a slave may hold the line low.
   assign scl_in = ~pull_low & ~stretch;

   scl_timebase u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .iface_en      (en),
      .ref_div       (pre),
      .scl_div       (div),
      .xfer_run      (run),
      .scl_in        (scl_in),
      .ref_tick      (tick),
      .scl_pull_low  (pull_low),
      .scl_fall_stb  (fall_stb),
      .sda_shift_stb (mid_stb),
      .scl_rise_stb  (rise_stb)
   );

   // pre, lo, hi, exp low cycles, exp mid offset, exp rise offset, exp period
   localparam int NV = 7;
   localparam int VEC [NV][7] = '{
      '{  1,   1,   1,   1,   1,   2,   3},
      '{  0,   0,   0,   1,   1,   2,   3},
      '{  3,   4,   2,  12,   6,  13,  19},
      '{  2,   5,   3,  10,   6,  11,  17},
      '{  1, 255, 255, 255, 128, 256, 511},
      '{  5,   2,   7,  10,   5,  11,  46},
      '{127,   3,   1, 381, 254, 382, 509}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_period(input int p, input int lo, input int hi, input int s_n,
                            input bit keep_run, input int max_n,
                            output int t_low, output int t_mid, output int t_rise,
                            output int t_per, output int n_fall, output int n_both);
      int  t0 = -1;
      int  rel = 0;
      bit  seen_low = 1'b0;
      bit  done = 1'b0;
      t_low = 0; t_mid = -1; t_rise = -1; t_per = -1; n_fall = 0; n_both = 0;
      @(posedge clk); #1;
      pre = 7'(p); div = {8'(hi), 8'(lo)}; stretch = (s_n > 0); en = 1'b1; run = 1'b1;
      for (int n = 0; n < max_n && !done; n++) begin
         @(negedge clk);
         if (fall_stb && rise_stb) n_both++;
         if (fall_stb) begin
            n_fall++;
            if (t0 < 0) t0 = n;
            else begin t_per = n - t0; done = 1'b1; end
         end
         if (t0 >= 0 && !done) begin
            if (pull_low) begin t_low++; seen_low = 1'b1; end
            if (mid_stb && t_mid < 0) t_mid = n - t0;
            if (rise_stb && t_rise < 0) t_rise = n - t0;
            if (seen_low && !pull_low) rel++;
         end
         @(posedge clk); #1;
         if (seen_low && rel >= s_n) stretch = 1'b0;
         if (t0 >= 0 && !keep_run) run = 1'b0;
      end
      run = 1'b0; en = 1'b0; stretch = 1'b0;
      repeat (2) @(posedge clk);
      #1;
   endtask

   initial begin
      int lw, md, rs, pr, nf, nb, cnt, first;
      en = 1'b1; run = 1'b0; pre = 7'd1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R2 reset pull_low", int'(pull_low), 0);
      chk("R2 reset fall", int'(fall_stb), 0);
      en = 1'b0;
      @(posedge clk); #1;

      // R1: tick spacing with prescale 4
      pre = 7'd4; en = 1'b1; cnt = 0; first = -1;
      for (int n = 0; n < 40; n++) begin
         @(negedge clk);
         if (tick) begin cnt++; if (first < 0) first = n; end
         @(posedge clk); #1;
      end
      chk("R1 tick count", cnt, 10);
      chk("R1 first tick", first, 3);
      en = 1'b0;
      @(posedge clk); #1;

      // Table of full SCL periods (R3 R4 R5 R7 R8 R9)
      for (int v = 0; v < NV; v++) begin
         do_period(VEC[v][0], VEC[v][1], VEC[v][2], 0, 1'b1, 1200, lw, md, rs, pr, nf, nb);
         chk("R4 low length", lw, VEC[v][3]);
         chk("R5 mid offset", md, VEC[v][4]);
         chk("R6 rise offset", rs, VEC[v][5]);
         chk("R8 period", pr, VEC[v][6]);
         chk("R9 fall/rise overlap", nb, 0);
      end

      // R6: slave stretch of five cycles
      do_period(1, 2, 2, 5, 1'b1, 200, lw, md, rs, pr, nf, nb);
      chk("R6 stretch low", lw, 2);
      chk("R6 stretch rise", rs, 8);
      chk("R6 stretch period", pr, 10);

      // R7: run dropped, return to idle after high phase
      do_period(1, 1, 3, 0, 1'b0, 40, lw, md, rs, pr, nf, nb);
      chk("R7 single fall", nf, 1);
      chk("R7 low once", lw, 1);
      chk("R7 no restart", pr, -1);

      // R2: disable during low, then re-enable
      @(posedge clk); #1;
      pre = 7'd1; div = {8'd1, 8'd10}; en = 1'b1; run = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R3 low active", int'(pull_low), 1);
      @(posedge clk); #1;
      en = 1'b0; run = 1'b0;
      @(negedge clk);
      chk("R2 off pull_low", int'(pull_low), 0);
      chk("R2 off tick", int'(tick), 0);
      repeat (3) @(posedge clk);
      #1;
      pre = 7'd4; en = 1'b1; cnt = 0; first = -1;
      for (int n = 0; n < 8; n++) begin
         @(negedge clk);
         if (tick && first < 0) first = n;
         if (pull_low) cnt++;
         @(posedge clk); #1;
      end
      chk("R2 restart first tick", first, 3);
      chk("R2 idle after enable", cnt, 0);
      en = 1'b0;

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #800000;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule